// File: doc/BRIEF.md
# Multiplierless Power-Line Notch Filter

This block is a fixed second-order recursive notch filter for one stream of signed Q15 biosignal samples taken at 250 Hz. It suppresses 50 Hz mains pickup, which sits at 0.4 of the Nyquist frequency. Every coefficient is a power of two or the sum or difference of two powers of two. Each product is therefore a wired shift, and where needed one adder. The block contains no multiplier.

A new sample is presented with a one-cycle valid strobe. The filtered result appears one clock later together with its own valid strobe. The input valid may stay low for any number of cycles between samples, so the filter can sit behind a slow sampling front end that runs on a fast system clock.

Internally the sum carries three fraction bits and four integer guard bits above the 16-bit sample. The result is rounded to nearest and clamped to the 16-bit signed range.

The feedback terms use coefficients of 0.5 and 0.75. This places the poles at radius sqrt(0.75) ≈ 0.866, at about 73 degrees, which is strictly inside the unit circle. The zeros sit on the unit circle at about 72 degrees.

Top module: `notch_sa_biquad`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears both input-history and both output-history registers to zero, and it clears `out_valid` and `out_data` to zero. With cleared history, the next output equals its input sample.
- R2: Each rising edge with `in_valid` high produces exactly one result. That result appears with `out_valid` high in the following cycle. `out_valid` is low in every cycle that does not follow an accepted sample.
- R3: Treat samples as signed integers x and results as y. Each result is y[n] = x[n] − 0.625·x[n−1] + x[n−2] + 0.5·y[n−1] − 0.75·y[n−2]. The history values y[n−1] and y[n−2] are the results actually emitted. The products use only the fixed right shifts by 1 and 3 (on x[n−1]), by 1 (on y[n−1]) and by 2 (on y[n−2]), plus two adders inside the products.
- R4: Before clamping, the exact value lies on a grid of 1/8. It is rounded to the nearest integer, and exact halves go toward positive infinity. For example, −37.5 becomes −37 and −130.5 becomes −130.5+0.5 = −130, while −131.0 stays −131.
- R5: A rounded value above 32767 is emitted as 32767, and one below −32768 is emitted as −32768. Such values never wrap.
- R6: Cycles with `in_valid` low leave all history unchanged, and `out_data` keeps its last value. A sequence fed with idle gaps therefore gives the same results as the same sequence fed back to back.
- R7: Feed a 50 Hz tone at 250 Hz (period of 5 samples) with amplitude 10000. After 100 samples, every output has magnitude below 600. A constant input of 10000 settles to about 11000 (DC gain 1.375/1.25 = 1.1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High for one cycle per new sample |
| in_data | input | 16 | Signed Q15 input sample |
| out_valid | output | 1 | High for one cycle per filtered result |
| out_data | output | 16 | Signed Q15 filtered result, held between results |

## Verification
A scaled impulse is fed back to back and compared against hand-worked values. This separates the feedforward taps from the two feedback taps, and it lands on exact half-way cases that show the rounding direction.

Full-scale positive and negative steps push the sum past the output range on the third sample, which distinguishes clamping from wrap-around.

A sequence with long idle gaps is compared against a reference that only advances on accepted samples. This shows whether idle cycles disturb the state.

A sampled 50 Hz tone is contrasted with a constant input. Together they show the notch itself: deep attenuation at 0.4 of Nyquist, with near-unity gain at DC.

// File: rtl/notch_pkg.sv
// Package: shared sizing and coefficient-shift constants for the notch filter.
// Assumes the largest coefficient shift never exceeds FRAC_W, so every
// shifted product is exact on the internal fraction grid.
package notch_pkg;

    // Sample width (Q15 two's complement).
    localparam int DATA_W  = 16;
    // Integer guard bits above the sample range.
    localparam int GUARD_W = 4;
    // Fraction bits below the sample LSB (covers the deepest shift).
    localparam int FRAC_W  = 3;
    // Number of past samples kept for each of input and output.
    localparam int HIST_D  = 2;

    // Feedforward middle tap: 0.5 + 0.125 = 0.625 (approximates 2cos(w0)).
    localparam int B1_SH_HI = 1;
    localparam int B1_SH_LO = 3;
    // First feedback tap: 0.5.
    localparam int A1_SH    = 1;
    // Second feedback tap: 1 - 0.25 = 0.75 (pole radius squared).
    localparam int A2_SH    = 2;

endpackage

// File: rtl/notch_hist.sv
// Module: notch_hist
// A chain of DEPTH enabled registers holding the most recent samples.
// taps[0] is the newest stored value, taps[DEPTH-1] the oldest.
// Assumes a synchronous active-low reset that clears every stage.
module notch_hist #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [W-1:0]            din,
    output logic [DEPTH-1:0][W-1:0] taps
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        logic [W-1:0] d;
        logic [W-1:0] q;

        if (s == 0) begin : g_head
            assign d = din;
        end else begin : g_body
            assign d = taps[s-1];
        end

        // Stage register: clear on reset, shift only on an accepted sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (en) begin
                q <= d;
            end
        end

        assign taps[s] = q;
    end

endmodule

// File: rtl/notch_shift_add.sv
// Module: notch_shift_add
// Combinational shift-add network forming the unrounded biquad sum
//   x0 - 0.625*x1 + x2 + 0.5*y1 - 0.75*y2
// on a grid with FRAC_W fraction bits. There are no multipliers: each
// product is a fixed arithmetic shift, and the two compound coefficients
// each need one adder. Assumes every shift amount is <= FRAC_W.
module notch_shift_add #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4,
    parameter int FRAC_W  = 3,
    parameter int B1_HI   = 1,
    parameter int B1_LO   = 3,
    parameter int A1_S    = 1,
    parameter int A2_S    = 2,
    localparam int ACC_W  = DATA_W + GUARD_W + FRAC_W
) (
    input  logic signed [DATA_W-1:0] x0,
    input  logic signed [DATA_W-1:0] x1,
    input  logic signed [DATA_W-1:0] x2,
    input  logic signed [DATA_W-1:0] y1,
    input  logic signed [DATA_W-1:0] y2,
    output logic signed [ACC_W-1:0]  acc
);

    localparam int EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] x0_e, x1_e, x2_e, y1_e, y2_e;
    logic signed [ACC_W-1:0] x0_u, x2_u, y2_u;
    logic signed [ACC_W-1:0] x1_hi, x1_lo, y1_h, y2_q;
    logic signed [ACC_W-1:0] p_b1, p_a2;
    logic signed [ACC_W-1:0] ff_sum, fb_sum;

    // Sign extension of every operand to the accumulator width.
    always_comb begin
        x0_e = {{EXT_W{x0[DATA_W-1]}}, x0};
        x1_e = {{EXT_W{x1[DATA_W-1]}}, x1};
        x2_e = {{EXT_W{x2[DATA_W-1]}}, x2};
        y1_e = {{EXT_W{y1[DATA_W-1]}}, y1};
        y2_e = {{EXT_W{y2[DATA_W-1]}}, y2};
    end

    // Wired shifts: align to the fraction grid, then divide by 2^k.
    always_comb begin
        x0_u  = x0_e <<< FRAC_W;
        x2_u  = x2_e <<< FRAC_W;
        y2_u  = y2_e <<< FRAC_W;
        x1_hi = x1_e <<< (FRAC_W - B1_HI);
        x1_lo = x1_e <<< (FRAC_W - B1_LO);
        y1_h  = y1_e <<< (FRAC_W - A1_S);
        y2_q  = y2_e <<< (FRAC_W - A2_S);
    end

    // Compound products: one adder each.
    always_comb begin
        p_b1 = x1_hi + x1_lo;
        p_a2 = y2_u - y2_q;
    end

    // Final summation of feedforward and feedback branches.
    always_comb begin
        ff_sum = x0_u + x2_u - p_b1;
        fb_sum = y1_h - p_a2;
        acc    = ff_sum + fb_sum;
    end

endmodule

// File: rtl/notch_round_sat.sv
// Module: notch_round_sat
// Rounds a sum with FRAC_W fraction bits to the nearest integer, with
// halves going toward +infinity, then clamps to the signed DATA_W range.
// Assumes FRAC_W >= 1 and that ACC_W has headroom for the rounding bias.
module notch_round_sat #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 23,
    parameter int FRAC_W = 3
) (
    input  logic signed [ACC_W-1:0]  acc,
    output logic signed [DATA_W-1:0] y
);

    localparam int HALF_I = 1 << (FRAC_W - 1);
    localparam int MAX_I  = (1 << (DATA_W - 1)) - 1;
    localparam int MIN_I  = -(1 << (DATA_W - 1));

    logic signed [ACC_W-1:0] half_c, max_c, min_c;
    logic signed [ACC_W-1:0] biased, rnd;

    // Constant rounding bias and clamp limits at accumulator width.
    always_comb begin
        half_c = ACC_W'(HALF_I);
        max_c  = ACC_W'(MAX_I);
        min_c  = ACC_W'(MIN_I);
    end

    // Round half up: add half an LSB, then drop the fraction bits.
    always_comb begin
        biased = acc + half_c;
        rnd    = biased >>> FRAC_W;
    end

    // Clamp into the output range instead of wrapping.
    always_comb begin
        if (rnd > max_c) begin
            y = max_c[DATA_W-1:0];
        end else if (rnd < min_c) begin
            y = min_c[DATA_W-1:0];
        end else begin
            y = rnd[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/notch_sa_biquad.sv
// Module: notch_sa_biquad (top)
// Fixed 50 Hz notch for a 250 Hz Q15 stream, built as one second-order
// recursive section with shift-add coefficients. Each accepted sample
// produces one rounded, clamped result one clock later.
// Assumes in_valid is a one-cycle strobe per sample; idle cycles are free.
module notch_sa_biquad #(
    parameter int DATA_W  = notch_pkg::DATA_W,
    parameter int GUARD_W = notch_pkg::GUARD_W,
    parameter int FRAC_W  = notch_pkg::FRAC_W,
    parameter int HIST_D  = notch_pkg::HIST_D
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int ACC_W = DATA_W + GUARD_W + FRAC_W;

    logic [HIST_D-1:0][DATA_W-1:0] x_taps;
    logic [HIST_D-1:0][DATA_W-1:0] y_taps;
    logic signed [ACC_W-1:0]       acc;
    logic signed [DATA_W-1:0]      y_next;

    // Past inputs x[n-1], x[n-2].
    notch_hist #(.W(DATA_W), .DEPTH(HIST_D)) u_xhist (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .din   (in_data),
        .taps  (x_taps)
    );

    // Past emitted outputs y[n-1], y[n-2].
    notch_hist #(.W(DATA_W), .DEPTH(HIST_D)) u_yhist (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .din   (y_next),
        .taps  (y_taps)
    );

    notch_shift_add #(
        .DATA_W  (DATA_W),
        .GUARD_W (GUARD_W),
        .FRAC_W  (FRAC_W),
        .B1_HI   (notch_pkg::B1_SH_HI),
        .B1_LO   (notch_pkg::B1_SH_LO),
        .A1_S    (notch_pkg::A1_SH),
        .A2_S    (notch_pkg::A2_SH)
    ) u_net (
        .x0  (in_data),
        .x1  (x_taps[0]),
        .x2  (x_taps[1]),
        .y1  (y_taps[0]),
        .y2  (y_taps[1]),
        .acc (acc)
    );

    notch_round_sat #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W)
    ) u_rs (
        .acc (acc),
        .y   (y_next)
    );

    // Output register: one-cycle valid per sample, data held when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= y_next;
            end
        end
    end

endmodule

// File: rtl/notch_sa_biquad_chk.sv
// Module: notch_sa_biquad_chk
// Property checker bound to notch_sa_biquad. It watches the handshake,
// the history registers and the output register over time.
module notch_sa_biquad_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [DATA_W-1:0] x_d1,
    input logic [DATA_W-1:0] x_d2,
    input logic [DATA_W-1:0] y_d1,
    input logic [DATA_W-1:0] y_d2
);

    logic rst_seen = 1'b0;

    // Remember whether reset was applied at the previous edge.
    always @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R1
    always @(posedge clk) begin
        if (rst_seen) begin
            reset_clear_chk: assert (!out_valid && out_data == '0 &&
                                     x_d1 == '0 && x_d2 == '0 &&
                                     y_d1 == '0 && y_d2 == '0)
                else $error("reset did not clear state");
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R3
    x_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (x_d1 == $past(in_data) && x_d2 == $past(x_d1)));

    // R3
    y_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (y_d1 == out_data && y_d2 == $past(y_d1)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(x_d1) && $stable(x_d2) &&
                       $stable(y_d1) && $stable(y_d2)));

endmodule

bind notch_sa_biquad notch_sa_biquad_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .x_d1      (x_taps[0]),
    .x_d2      (x_taps[1]),
    .y_d1      (y_taps[0]),
    .y_d2      (y_taps[1])
);

// File: tb/sim_notch_sa_biquad.sv
module sim_notch_sa_biquad;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference history: advances only on accepted samples.
    int mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;

    // Impulse of 800 fed back to back: {input, expected output}.
    localparam int NV = 7;
    localparam int VEC [NV][2] = '{
        '{800,  800}, '{0, -100}, '{0, 150}, '{0, 150},
        '{0,   -37}, '{0, -131}, '{0, -38}
    };

    always #10 clk = ~clk;

    notch_sa_biquad u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int model_eval(input int x);
        int acc8;
        int r;
        // 8*y = 8x - 5x1 + 8x2 + 4y1 - 6y2  (coefficients 1, -0.625, 1, 0.5, -0.75)
        acc8 = 8 * x - 5 * mx1 + 8 * mx2 + 4 * my1 - 6 * my2;
        r = (acc8 + 4) >>> 3;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic model_step(input int x, output int y);
        y   = model_eval(x);
        mx2 = mx1; mx1 = x;
        my2 = my1; my1 = y;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    // Send one sample with a gap after it; check the result against the model.
    task automatic push(input int x, input string req, output int y);
        int e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
        model_step(x, e);
        chk({req, " valid"}, int'(out_valid), 1);
        chk(req, int'(out_data), e);
        y = int'(out_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int y;
        int held;
        int big;

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset data", int'(out_data), 0);

        // R3/R4: table walked back to back
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R3/R4 table valid", int'(out_valid), 1);
                chk("R3/R4 table", int'(out_data), VEC[i-1][1]);
            end
            if (i < NV) begin
                in_valid = 1'b1;
                in_data  = 16'(VEC[i][0]);
            end else begin
                in_valid = 1'b0;
            end
        end

        // R1: reset mid-run, then the impulse repeats from clean state
        do_reset();
        push(800, "R1 first after reset", y);
        chk("R1 output equals input", y, 800);
        push(0, "R3 second after reset", y);
        chk("R3 second tap", y, -100);

        // R2: one result per sample, exactly one cycle later
        @(negedge clk);
        chk("R2 no extra valid", int'(out_valid), 0);
        push(1234, "R2 single sample", y);
        @(negedge clk);
        chk("R2 valid drops", int'(out_valid), 0);

        // R6: idle gaps hold state and output
        held = int'(out_data);
        idle(17);
        chk("R6 data held", int'(out_data), held);
        chk("R6 valid low idle", int'(out_valid), 0);
        push(-5000, "R6 after gap", y);
        idle(40);
        push(3000, "R6 after long gap", y);
        push(0, "R6 continue", y);

        // R5: positive overflow clamps at the third sample
        do_reset();
        push(32767, "R5 pos n0", y);
        push(32767, "R5 pos n1", y);
        chk("R5 pos n1 value", y, 28671);
        push(32767, "R5 pos n2", y);
        chk("R5 pos clamp", y, 32767);

        // R5: negative overflow clamps
        do_reset();
        push(-32768, "R5 neg n0", y);
        push(-32768, "R5 neg n1", y);
        chk("R5 neg n1 value", y, -28672);
        push(-32768, "R5 neg n2", y);
        chk("R5 neg clamp", y, -32768);

        // R7: 50 Hz tone at 250 Hz is suppressed
        do_reset();
        for (int n = 0; n < 140; n++) begin
            push($rtoi(10000.0 * $cos(2.0 * 3.14159265358979 * n / 5.0)), "R7 tone", y);
            if (n >= 100) begin
                big = (y > 599 || y < -599) ? 1 : 0;
                chk("R7 tone attenuated", big, 0);
            end
        end

        // R7: DC passes with gain about 1.1
        do_reset();
        for (int n = 0; n < 80; n++) begin
            push(10000, "R7 dc", y);
        end
        big = (y > 10950 && y < 11050) ? 1 : 0;
        chk("R7 dc gain", big, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule